// File: doc/BRIEF.md
# Split 5+4 Lookup-Table Logic Element

A programmable logic element with six data inputs and one output. It holds a 32-entry table addressed by the low five inputs and a 16-entry table addressed by the low four inputs. The sixth input, compared against a single polarity cell, chooses which table drives the output. With 49 configuration cells instead of 64, it covers every function of up to five inputs. It also covers every six-input function in which one input value collapses the function onto at most four of the remaining inputs. The sixth input is that collapsing input, and the polarity cell records which of its values does the collapsing.

Configuration is written serially. Each rising clock edge with the load enable high shifts one bit into the chain. Bits travel from the top cell toward cell 0, and cell 0 is visible on a serial output so that elements can be daisy-chained. Once loaded, the path from data inputs to output is purely combinational.

Top module: `lut54_le`

## Requirements
- R1: After reset (rst_ni low) every configuration cell is 0, so out_o is 0 for all 64 values of data_i, and cfg_q_o is 0.
- R2: Configuration words are 49 bits, indexed 0 to 48. Cells 0 to 31 form the large table, with entry n at cell n. Cells 32 to 47 form the small table, with entry n at cell 32+n. Cell 48 is the polarity cell. On each rising edge with cfg_en_i high, cell 48 takes cfg_d_i and cell k takes cell k+1. Shifting bit 0 of a word first and bit 48 last therefore loads the word exactly.
- R3: cfg_q_o shows cell 0 at all times. While a new word is shifted in, the previous word leaves on cfg_q_o in the order bit 0, bit 1, and so on up to bit 48, one bit per enabled edge.
- R4: While cfg_en_i is low, cfg_d_i is ignored and the configuration and the output function do not change.
- R5: When data_i[5] differs from the polarity cell, out_o equals large-table entry data_i[4:0], where data_i[0] is the least significant address bit.
- R6: When data_i[5] equals the polarity cell, out_o equals small-table entry data_i[3:0]. In this case data_i[4] has no effect.
- R7: With data_i[5] held at the inverse of the polarity cell, any function of data_i[4:0] loaded into the large table appears on out_o unchanged.
- R8: out_o follows a change of data_i without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Configuration shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all cells |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_d_i | input | 1 | Serial configuration bit entering cell 48 |
| data_i | input | 6 | Logic inputs; bit 0 is the lowest table address bit, bit 5 is the table-select input |
| cfg_q_o | output | 1 | Serial configuration bit leaving cell 0 |
| out_o | output | 1 | Logic output |

## Verification
The assertions check at rising clock edges, so they take for granted that cfg_en_i, cfg_d_i and data_i are settled at every edge. The assertions comparing the tables against the output also assume data_i carries no unknown bits once reset is released. The bench changes every input only on the falling edge, or between edges at least a nanosecond before it samples the output, and it drives data_i to a defined value throughout the run. The trimming functions it programs are built from a random polarity and two random tables. Each one is checked through all 64 input combinations against a truth table formed from the requirements.

// File: rtl/lut54_pkg.sv
package lut54_pkg;
  localparam int BIG_K   = 5;
  localparam int SMALL_K = 4;
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int N = 49
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [N-1:0] cells_o,
  output logic         q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cells_o <= '0;
    else if (en_i) cells_o <= {d_i, cells_o[N-1:1]};
  end

  assign q_o = cells_o[0];

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cells_o[N-1] == $past(d_i));

  // R3
  shift_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(cells_o[1]));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cells_o));
endmodule

// File: rtl/lut_tree.sv
module lut_tree #(
  parameter int K = 4,
  localparam int CELLS = 2**K
) (
  input  logic [CELLS-1:0] cells_i,
  input  logic [K-1:0]     addr_i,
  output logic             out_o
);
  // level l holds 2**(K-l) nodes; level 0 is the cells, level K the root
  for (genvar l = 0; l <= K; l++) begin : g_lvl
    logic [(2**(K-l))-1:0] node;
    if (l == 0) begin : g_leaf
      assign node = cells_i;
    end else begin : g_mux
      for (genvar n = 0; n < 2**(K-l); n++) begin : g_n
        assign node[n] = addr_i[l-1] ? g_lvl[l-1].node[2*n+1]
                                     : g_lvl[l-1].node[2*n];
      end
    end
  end

  assign out_o = g_lvl[K].node[0];
endmodule

// File: rtl/lut54_le.sv
module lut54_le #(
  parameter int BIG_K   = lut54_pkg::BIG_K,
  parameter int SMALL_K = lut54_pkg::SMALL_K
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_en_i,
  input  logic           cfg_d_i,
  input  logic [BIG_K:0] data_i,
  output logic           cfg_q_o,
  output logic           out_o
);
  localparam int BIG_CELLS   = 2**BIG_K;
  localparam int SMALL_CELLS = 2**SMALL_K;
  localparam int CFG_BITS    = BIG_CELLS + SMALL_CELLS + 1;

  logic [CFG_BITS-1:0]    cells;
  logic [BIG_CELLS-1:0]   big_cells;
  logic [SMALL_CELLS-1:0] small_cells;
  logic                   pol;
  logic                   big_out, small_out, sel_small;

  cfg_chain #(.N(CFG_BITS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_en_i),
    .d_i     (cfg_d_i),
    .cells_o (cells),
    .q_o     (cfg_q_o)
  );

  assign big_cells   = cells[BIG_CELLS-1:0];
  assign small_cells = cells[BIG_CELLS +: SMALL_CELLS];
  assign pol         = cells[CFG_BITS-1];

  lut_tree #(.K(BIG_K)) u_big (
    .cells_i (big_cells),
    .addr_i  (data_i[BIG_K-1:0]),
    .out_o   (big_out)
  );

  lut_tree #(.K(SMALL_K)) u_small (
    .cells_i (small_cells),
    .addr_i  (data_i[SMALL_K-1:0]),
    .out_o   (small_out)
  );

  // select input matching the polarity cell routes the small cofactor
  assign sel_small = ~(data_i[BIG_K] ^ pol);
  assign out_o     = sel_small ? small_out : big_out;

  // R5
  big_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    big_out == big_cells[data_i[BIG_K-1:0]]);

  // R6
  small_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    small_out == small_cells[data_i[SMALL_K-1:0]]);
endmodule

// File: tb/sim_lut54_le.sv
module sim_lut54_le;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_d = 1'b0;
  logic [5:0] data = '0;
  logic       cfg_q, out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lut54_le u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_d_i(cfg_d),
    .data_i(data), .cfg_q_o(cfg_q), .out_o(out)
  );

  function automatic logic [63:0] make_tt(logic [31:0] f5, logic [15:0] f4, logic s);
    logic [63:0] t;
    for (int d = 0; d < 64; d++) begin
      logic [5:0] a;
      a = 6'(d);
      t[d] = (a[5] == s) ? f4[a[3:0]] : f5[a[4:0]];
    end
    return t;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (data=%0d)", req, act, exp, data);
    end
  endtask

  // shift word bit 0 first; optionally check the old word leaving on cfg_q
  task automatic load(logic [48:0] w, bit chk_out, logic [48:0] old_w);
    for (int i = 0; i < 49; i++) begin
      @(negedge clk);
      if (chk_out) chk("R3", cfg_q, old_w[i]);
      cfg_en = 1'b1;
      cfg_d  = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_d  = 1'b0;
  endtask

  task automatic check_all(string req, logic [63:0] tt);
    for (int d = 0; d < 64; d++) begin
      data = 6'(d);
      #1;
      chk(req, out, tt[d]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [48:0] prev, w;
    logic [31:0] f5;
    logic [15:0] f4;
    logic        s;
    logic [31:0] r;
    void'($urandom(32'd20110126));

    #23;
    // R1 reset state
    chk("R1", cfg_q, 1'b0);
    check_all("R1", 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1", 64'd0);
    prev = '0;

    // R5 R6: s=0, large all ones, small all zeros
    f5 = '1; f4 = '0; s = 1'b0;
    w = {s, f4, f5};
    load(w, 1'b1, prev); prev = w;
    check_all("R5", make_tt(f5, f4, s));

    // R6 polarity 1: large = buffer of i1, small = buffer of i4
    f5 = 32'hAAAA_AAAA; f4 = 16'hFF00; s = 1'b1;
    w = {s, f4, f5};
    load(w, 1'b1, prev); prev = w;
    check_all("R6", make_tt(f5, f4, s));

    // R8: output follows data with no clock, between edges
    @(negedge clk);
    data = 6'b100000; #1; chk("R8", out, 1'b0);
    data = 6'b101000; #1; chk("R8", out, 1'b1);
    data = 6'b000001; #1; chk("R8", out, 1'b1);

    // random trimming functions
    for (int k = 0; k < 24; k++) begin
      f5 = $urandom();
      r  = $urandom();
      f4 = r[15:0];
      s  = r[16];
      w  = {s, f4, f5};
      load(w, 1'b1, prev); prev = w;
      check_all("R2", make_tt(f5, f4, s));
      // R6: i5 has no effect on the small path
      for (int d = 0; d < 16; d++) begin
        logic a, b;
        data = {s, 1'b0, 4'(d)}; #1; a = out;
        data = {s, 1'b1, 4'(d)}; #1; b = out;
        chk("R6", b, a);
      end
      // R7: i6 held at the inverse polarity gives the 5-input function
      for (int d = 0; d < 32; d++) begin
        data = {~s, 5'(d)}; #1;
        chk("R7", out, f5[d]);
      end
    end

    // R4: serial input toggles with enable low, nothing changes
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cfg_d = ~cfg_d;
    end
    @(negedge clk);
    cfg_d = 1'b0;
    chk("R4", cfg_q, prev[0]);
    check_all("R4", make_tt(prev[31:0], prev[47:32], prev[48]));

    // R3: flush the last word out
    load(49'd0, 1'b1, prev);
    check_all("R3", 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule